// File: doc/BRIEF.md
# Dithered Sigma-Delta Divide-Ratio Modulator

This block turns a static fractional frequency setting into a stream of integer divide ratios for a fractional-N loop. Once per reference period, marked by a one-cycle strobe, it produces a small signed offset that is added to the integer part of the setting. The long-run mean of that offset equals the fractional word scaled by 2^-FRAC_W. The offset comes from a cascade of first-order accumulators whose carries are merged through digital differencing. This pushes the quantization error toward high offset frequencies, where the loop filter removes it. The number of cascaded stages (1 to 3) is a parameter and should be matched to the order of the loop response.

A maximal-length shift-register sequence can add one extra count at the least significant bit of the first accumulator's input. This breaks up the short repeating patterns that simple fractions would otherwise produce. The divide value presented to the counter is the integer part plus the offset. Both are registered together, so the counter always sees a consistent pair for its next period.

Top module: `sdm_divctl`

## Requirements
- R1: The offset and divide value change only on a clock edge where `ref_tick` is 1. On all other edges they hold their values, and holding leaves the sequence produced by later ticks unchanged.
- R2: After each tick, `div_value` equals the `int_n` sampled on that tick plus the sign-extended `div_offset` produced by that tick, modulo 2^NINT_W.
- R3: `div_offset` always lies in the range 1-2^(ORDER-1) to 2^(ORDER-1). This is {0,1} for ORDER=1 and -3 to +4 for ORDER=3. With ORDER=3, an `int_n` of 5 or more therefore keeps `div_value` at 2 or above.
- R4: With ORDER=1 and dither off, every run of 2^FRAC_W consecutive offsets sums to exactly `frac_word`. The first n offsets after reset sum to floor(n·frac_word/2^FRAC_W).
- R5: With ORDER=3 and dither off, every run of 2^FRAC_W consecutive offsets sums to within ±3 of `frac_word`. The first n offsets after reset sum to between floor(n·frac_word/2^FRAC_W)-1 and that floor plus 2.
- R6: With `frac_word` = 0 and dither off, the offset remains 0 on every tick after reset.
- R7: With `dither_en` = 1, the first accumulator receives one extra LSB on each tick where the top bit of a maximal-length LFSR_W-bit sequence is 1. The sequence is seeded to 1 at reset and advances every tick. With `frac_word` = 0, the offset becomes nonzero. For ORDER=1, FRAC_W=6 and LFSR_W=7, the first 256 offsets sum to between 1 and 3.
- R8: A synchronous active-low reset clears every accumulator, difference delay and LFSR state, and sets `div_offset` and `div_value` to 0. The tick sequence after a reset repeats, value for value, the sequence after any earlier reset with the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference period; advances the modulator |
| dither_en | input | 1 | Enables the pseudo-random LSB dither |
| frac_word | input | FRAC_W | Fractional part of the divide setting, in units of 2^-FRAC_W |
| int_n | input | NINT_W | Integer part of the divide setting |
| div_offset | output | 4 | Signed offset from the current tick (two's complement) |
| div_value | output | NINT_W | Divide value for the next divider period: int_n + div_offset |

## Verification
The bench builds two copies of the block with FRAC_W=6 and LFSR_W=7. One is third-order and the other first-order, and they share the same inputs. With a 64-step fraction, every fraction word can be swept. Each sweep step runs three full accumulator periods, and every sliding 64-tick window is checked for its mean and range. The short LFSR makes the dither's added count predictable within a few hundred ticks. Gapped strobes, and a reset issued from a busy state, are compared against an uninterrupted reference run.

// File: rtl/sdm_pkg.sv
// Shared types and helpers for the sigma-delta divide modulator.
// Assumes offsets fit in four signed bits (cascade order of at most 3).
package sdm_pkg;

    localparam int OFS_W = 4;

    typedef logic signed [OFS_W-1:0] ofs_t;

    // Feedback tap mask for a maximal-length Fibonacci shift register.
    // Bit i of the mask selects state bit i for the parity feedback.
    function automatic logic [31:0] lfsr_mask(input int width);
        case (width)
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0E08;
            13:      return 32'h0000_1C80;
            14:      return 32'h0000_3802;
            15:      return 32'h0000_6000;
            default: return 32'h0000_D008;
        endcase
    endfunction

endpackage

// File: rtl/sdm_lfsr.sv
// Maximal-length pseudo-random bit source for input dither.
// Assumes W is between 3 and 16. Advances only when adv is high; seeded to 1 by reset.
module sdm_lfsr #(
    parameter int W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic bit_out
);
    import sdm_pkg::*;

    localparam logic [W-1:0] MASK = W'(lfsr_mask(W));

    logic [W-1:0] state_q;
    logic         fb;

    // Parity of the tapped bits forms the next low bit.
    assign fb = ^(state_q & MASK);

    // Shift the register one place per reference tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W'(1);
        end else if (adv) begin
            state_q <= {state_q[W-2:0], fb};
        end
    end

    assign bit_out = state_q[W-1];

endmodule

// File: rtl/sdm_addcarry.sv
// One accumulator adder of the cascade: residue plus input plus an LSB carry-in.
// Purely combinational; the owning module holds the residue register.
module sdm_addcarry #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] addend,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] total;

    // Full-width add; the top bit is the overflow carry.
    always_comb begin
        total = {1'b0, acc} + {1'b0, addend} + (W+1)'(cin);
    end

    assign sum  = total[W-1:0];
    assign cout = total[W];

endmodule

// File: rtl/sdm_recomb.sv
// Merges stage carries into one signed offset:
//   y = c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3, keeping only terms up to ORDER.
// Delay registers advance only on a reference tick.
module sdm_recomb #(
    parameter int ORDER = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [2:0]        carry_vec,
    output sdm_pkg::ofs_t     y
);
    import sdm_pkg::*;

    int t2;
    int t3;

    if (ORDER >= 2) begin : g_d2
        logic c2_d;
        // First difference delay for the second stage carry.
        always_ff @(posedge clk) begin
            if (!rst_n)   c2_d <= 1'b0;
            else if (adv) c2_d <= carry_vec[1];
        end
        assign t2 = int'(carry_vec[1]) - int'(c2_d);
    end else begin : g_n2
        assign t2 = 0;
    end

    if (ORDER >= 3) begin : g_d3
        logic c3_d;
        logic c3_dd;
        // Two-deep delay line for the second difference of the third carry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c3_d  <= 1'b0;
                c3_dd <= 1'b0;
            end else if (adv) begin
                c3_d  <= carry_vec[2];
                c3_dd <= c3_d;
            end
        end
        assign t3 = int'(carry_vec[2]) - 2 * int'(c3_d) + int'(c3_dd);
    end else begin : g_n3
        assign t3 = 0;
    end

    // Sum of the differenced carries, narrowed to the offset type.
    always_comb begin
        y = ofs_t'(int'(carry_vec[0]) + t2 + t3);
    end

endmodule

// File: rtl/sdm_divctl.sv
// Top of the dithered cascade sigma-delta divide-ratio modulator.
// Assumes ORDER in 1..3, NINT_W > 4, and one ref_tick per reference period.
// On each tick, all stages advance and div_offset/div_value take the new ratio.
module sdm_divctl #(
    parameter int FRAC_W = 16,
    parameter int ORDER  = 3,
    parameter int LFSR_W = 15,
    parameter int NINT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_tick,
    input  logic                  dither_en,
    input  logic [FRAC_W-1:0]     frac_word,
    input  logic [NINT_W-1:0]     int_n,
    output logic signed [3:0]     div_offset,
    output logic [NINT_W-1:0]     div_value
);
    import sdm_pkg::*;

    localparam int SEXT_W = NINT_W - OFS_W;

    logic              dith_bit;
    logic              dith_add;
    logic [FRAC_W-1:0] acc_q   [ORDER];
    logic [FRAC_W-1:0] sum_nxt [ORDER];
    logic [2:0]        carry_vec;
    ofs_t              y;

    sdm_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (ref_tick),
        .bit_out (dith_bit)
    );

    assign dith_add = dither_en & dith_bit;

    for (genvar i = 0; i < 3; i++) begin : g_stage
        if (i < ORDER) begin : g_on
            logic [FRAC_W-1:0] addend;
            logic              cin;
            if (i == 0) begin : g_first
                assign addend = frac_word;
                assign cin    = dith_add;
            end else begin : g_next
                assign addend = sum_nxt[i-1];
                assign cin    = 1'b0;
            end

            sdm_addcarry #(.W(FRAC_W)) u_add (
                .acc    (acc_q[i]),
                .addend (addend),
                .cin    (cin),
                .sum    (sum_nxt[i]),
                .cout   (carry_vec[i])
            );

            // Residue register of this accumulator stage.
            always_ff @(posedge clk) begin
                if (!rst_n)        acc_q[i] <= '0;
                else if (ref_tick) acc_q[i] <= sum_nxt[i];
            end
        end else begin : g_off
            assign carry_vec[i] = 1'b0;
        end
    end

    sdm_recomb #(.ORDER(ORDER)) u_recomb (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (ref_tick),
        .carry_vec (carry_vec),
        .y         (y)
    );

    // Register the offset and the combined divide value on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_offset <= '0;
            div_value  <= '0;
        end else if (ref_tick) begin
            div_offset <= y;
            div_value  <= int_n + {{SEXT_W{y[OFS_W-1]}}, y};
        end
    end

endmodule

// File: rtl/sdm_divctl_chk.sv
// Assertion checker for sdm_divctl, attached by bind below.
// Observes ports only; keeps one register of int_n for the sum check.
module sdm_divctl_chk #(
    parameter int ORDER  = 3,
    parameter int NINT_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ref_tick,
    input logic [NINT_W-1:0]     int_n,
    input logic signed [3:0]     div_offset,
    input logic [NINT_W-1:0]     div_value
);
    localparam int HI = 1 << (ORDER - 1);
    localparam int LO = 1 - HI;

    logic [NINT_W-1:0] int_n_q;

    // Remember the integer part offered on the previous edge.
    always_ff @(posedge clk) begin
        int_n_q <= int_n;
    end

    // R3
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(div_offset) >= LO) && (int'(div_offset) <= HI));

    // R1
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> ($stable(div_offset) && $stable(div_value)));

    // R2
    value_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> (div_value == NINT_W'(int'(int_n_q) + int'(div_offset))));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ((div_offset == 4'sd0) && (div_value == '0)));

endmodule

bind sdm_divctl sdm_divctl_chk #(.ORDER(ORDER), .NINT_W(NINT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick),
    .int_n      (int_n),
    .div_offset (div_offset),
    .div_value  (div_value)
);

// File: tb/sdm_divctl_test.sv
module sdm_divctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int FW   = 6;
    localparam int LW   = 7;
    localparam int NW   = 8;
    localparam int P    = 1 << FW;
    localparam int RUNL = 3 * P;
    localparam int NBASE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic dither_en = 1'b0;
    logic [FW-1:0] frac_word = '0;
    logic [NW-1:0] int_n = NW'(NBASE);
    logic signed [3:0] o3_ofs, o1_ofs;
    logic [NW-1:0] o3_dv, o1_dv;

    int errors = 0;
    int checks = 0;
    int s3 [RUNL];
    int s1 [RUNL];
    int r3 [RUNL];
    int dv_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdm_divctl #(.FRAC_W(FW), .ORDER(3), .LFSR_W(LW), .NINT_W(NW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .dither_en(dither_en),
        .frac_word(frac_word), .int_n(int_n), .div_offset(o3_ofs), .div_value(o3_dv));

    sdm_divctl #(.FRAC_W(FW), .ORDER(1), .LFSR_W(LW), .NINT_W(NW)) uut_o1 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .dither_en(dither_en),
        .frac_word(frac_word), .int_n(int_n), .div_offset(o1_ofs), .div_value(o1_dv));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_tick = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check(o3_ofs == 0 && o1_ofs == 0 && o3_dv == 0 && o1_dv == 0,
              "R8 reset outputs", int'(o3_ofs) + int'(o3_dv), 0);
        rst_n = 1'b1;
    endtask

    // Run n consecutive ticks, logging offsets and divide-value mismatches.
    task automatic run_ticks(input int n);
        dv_bad = 0;
        for (int k = 0; k < n; k++) begin
            ref_tick = 1'b1;
            @(posedge clk); #1;
            s3[k] = int'(o3_ofs);
            s1[k] = int'(o1_ofs);
            if (int'(o3_dv) != ((NBASE + s3[k]) & 255)) dv_bad++;
            if (int'(o1_dv) != ((NBASE + s1[k]) & 255)) dv_bad++;
        end
        ref_tick = 1'b0;
    endtask

    // Worst deviation of any P-long window sum from f.
    function automatic int worst_win(input int order, input int f, input int n);
        int worst = 0;
        for (int s = 0; s + P <= n; s++) begin
            int acc = 0;
            for (int k = s; k < s + P; k++) acc += (order == 3) ? s3[k] : s1[k];
            if ((acc - f) > worst || (f - acc) > worst) worst = (acc > f) ? acc - f : f - acc;
        end
        return worst;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int_n = NW'(NBASE);
        dither_en = 1'b0;

        // Full fraction sweep, dither off.
        for (int f = 0; f < P; f++) begin
            int bad3, bad1, sum3, sum1, w1, w3, nz;
            frac_word = FW'(f);
            do_reset();
            run_ticks(RUNL);
            bad3 = 0; bad1 = 0; sum3 = 0; sum1 = 0; nz = 0;
            for (int k = 0; k < RUNL; k++) begin
                if (s3[k] < -3 || s3[k] > 4) bad3++;
                if (s1[k] < 0 || s1[k] > 1) bad1++;
                sum3 += s3[k];
                sum1 += s1[k];
                if (s3[k] != 0 || s1[k] != 0) nz++;
            end
            check(bad3 == 0 && bad1 == 0, "R3 offset range", bad3 + bad1, 0);
            check(dv_bad == 0, "R2 div_value sum", dv_bad, 0);
            w1 = worst_win(1, f, RUNL);
            check(w1 == 0, "R4 order1 window", w1, 0);
            check(sum1 == (RUNL * f) / P, "R4 order1 cumulative", sum1, (RUNL * f) / P);
            w3 = worst_win(3, f, RUNL);
            check(w3 <= 3, "R5 order3 window", w3, 3);
            check(sum3 >= (RUNL * f) / P - 1 && sum3 <= (RUNL * f) / P + 2,
                  "R5 order3 cumulative", sum3, (RUNL * f) / P);
            if (f == 0) check(nz == 0, "R6 zero fraction", nz, 0);
        end

        // Reference run for the gap/reset test.
        frac_word = FW'(37);
        do_reset();
        run_ticks(RUNL);
        for (int k = 0; k < RUNL; k++) r3[k] = s3[k];

        // Busy state, then reset and rerun with idle gaps.
        run_ticks(17);
        do_reset();
        begin
            int mism = 0;
            int moved = 0;
            for (int k = 0; k < RUNL; k++) begin
                int_n = NW'(NBASE);
                ref_tick = 1'b1;
                @(posedge clk); #1;
                if (int'(o3_ofs) != r3[k]) mism++;
                if (k % 5 == 2) begin
                    logic signed [3:0] h_ofs;
                    logic [NW-1:0] h_dv;
                    h_ofs = o3_ofs;
                    h_dv = o3_dv;
                    ref_tick = 1'b0;
                    int_n = NW'(99);
                    for (int g = 0; g < 3; g++) begin
                        @(posedge clk); #1;
                        if (o3_ofs != h_ofs || o3_dv != h_dv) moved++;
                    end
                end
            end
            ref_tick = 1'b0;
            int_n = NW'(NBASE);
            check(moved == 0, "R1 hold without tick", moved, 0);
            check(mism == 0, "R1 R8 sequence after reset with gaps", mism, 0);
        end

        // Dither on, zero fraction.
        dither_en = 1'b1;
        frac_word = '0;
        do_reset();
        begin
            int sum1 = 0;
            int nz3 = 0;
            int nz1 = 0;
            int bad = 0;
            for (int k = 0; k < 256; k++) begin
                ref_tick = 1'b1;
                @(posedge clk); #1;
                sum1 += int'(o1_ofs);
                if (o3_ofs != 0) nz3++;
                if (o1_ofs != 0) nz1++;
                if (o3_ofs < -3 || o3_ofs > 4) bad++;
            end
            ref_tick = 1'b0;
            check(sum1 >= 1 && sum1 <= 3, "R7 dither mean order1", sum1, 2);
            check(nz3 > 0, "R7 dither busies order3", nz3, 1);
            check(nz1 > 0, "R7 dither busies order1", nz1, 1);
            check(bad == 0, "R3 range with dither", bad, 0);
        end

        // Dither on, full-scale fraction: range must still hold.
        frac_word = FW'(P - 1);
        do_reset();
        run_ticks(RUNL);
        begin
            int bad = 0;
            for (int k = 0; k < RUNL; k++) begin
                if (s3[k] < -3 || s3[k] > 4) bad++;
                if (s1[k] < 0 || s1[k] > 1) bad++;
            end
            check(bad == 0, "R3 range full scale dithered", bad, 0);
            check(dv_bad == 0, "R2 div_value dithered", dv_bad, 0);
        end

        // Dither changes the order-1 sequence for a mid fraction.
        begin
            int diff = 0;
            int keep [RUNL];
            frac_word = FW'(21);
            dither_en = 1'b0;
            do_reset();
            run_ticks(RUNL);
            for (int k = 0; k < RUNL; k++) keep[k] = s1[k];
            dither_en = 1'b1;
            do_reset();
            run_ticks(RUNL);
            for (int k = 0; k < RUNL; k++) if (keep[k] != s1[k]) diff++;
            check(diff > 0, "R7 dither alters sequence", diff, 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule